// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block lets a fixed group of N agents meet at a common synchronisation point in hardware. Each agent raises a one-cycle arrive strobe when it reaches the barrier. The block holds a private sense bit for every agent and flips it on entry. One shared tally counts the agents that have entered the current round. When the final agent of a round is counted, the tally clears and a single global flag flips to the new sense. Every agent whose sense now matches the flag sees its release output pulse, and all agents leave the round together.

The senses alternate from one round to the next. An agent that has just been released can therefore enter the next round at once: its new sense differs from the flag, so it cannot be released again until the next round completes. No second counter or drain phase is needed for this. Agents that arrive in the same cycle are all counted. A repeated strobe from an agent that is already waiting has no effect.

Top module: `sense_barrier`

## Requirements
- R1: After synchronous active-low reset the global flag and every private sense are 0, no agent is waiting, the tally is 0, and `release_o` is all zeros.
- R2: An arrive strobe from an agent that is not waiting enrolls that agent in the current round. No release occurs while fewer than N agents are enrolled.
- R3: Strobes from several agents in the same cycle are all counted in that cycle. When all N strobe together in an idle round, the round completes at once.
- R4: The clock edge that counts the N-th agent flips the global flag and clears the tally. In the cycle after that edge, every bit of `release_o` is 1 for exactly one cycle. In every other cycle `release_o` is all zeros.
- R5: An arrive strobe from an agent that is already waiting is ignored. This includes the cycle in which `release_o` is high. Such a strobe neither counts toward the round nor changes that agent's sense.
- R6: An agent that strobes in the cycle just after its release enrolls in the next round. It is not released until N agents have enrolled in that new round, so rounds can follow one another every two cycles.
- R7: A partly filled round keeps its enrolled agents waiting for any length of time until the remaining agents arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive_i | input | N | One-cycle arrive strobe, one bit per agent |
| release_o | output | N | Release pulse, one bit per agent |

## Verification
Agents arrive one at a time with gaps between them. This shows that the tally advances one step per strobe and that a partial round holds. All agents strobe in one cycle, and pairs strobe together. These cases show whether the tally adds a population count or only a single increment. Repeated strobes from agents that are already waiting, including during the release cycle, show whether the waiting guard works. Constant strobing, immediate re-entry and long random patterns show whether an agent that re-enters at once is ever released early by a flag left over from the previous round.

// File: rtl/barrier_pkg.sv
// Package: shared sizing helpers for the barrier unit.
// Assumes the participant count is at least 2.
package barrier_pkg;

    // Width of a tally that must hold values 0..n inclusive.
    function automatic int tally_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/barrier_slot.sv
// Module: barrier_slot
// Per-agent state: a private sense bit and a waiting bit.
// An arrive strobe is accepted only while the agent is not waiting. Acceptance
// flips the sense and marks the agent waiting. The agent is released when its
// sense matches the global flag, and the release clears waiting.
// Assumes the global flag changes only when the whole group has enrolled.
module barrier_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic flag_i,
    output logic accept_o,
    output logic release_o,
    output logic waiting_o,
    output logic sense_o
);

    logic sense_q;
    logic waiting_q;

    // Decide acceptance and release from the current state.
    always_comb begin
        accept_o  = arrive_i & ~waiting_q;
        release_o = waiting_q & (sense_q == flag_i);
    end

    // Flip the sense on entry; set waiting on entry and clear it on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q   <= 1'b0;
            waiting_q <= 1'b0;
        end else if (accept_o) begin
            sense_q   <= ~sense_q;
            waiting_q <= 1'b1;
        end else if (release_o) begin
            waiting_q <= 1'b0;
        end
    end

    assign waiting_o = waiting_q;
    assign sense_o   = sense_q;

endmodule

// File: rtl/barrier_tally.sv
// Module: barrier_tally
// Shared arrival tally and global flag.
// Each cycle it adds the number of accepted strobes to the tally. When the sum
// reaches N it clears the tally and flips the flag to the sense that the
// completing agents have just taken.
// Assumes each agent is accepted at most once per round, so the sum never
// exceeds N.
module barrier_tally #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] accept_i,
    output logic         flag_o
);
    import barrier_pkg::*;

    localparam int CW = tally_width(N);
    localparam int SW = CW + 1;

    logic [CW-1:0] tally_q;
    logic [SW-1:0] pop;
    logic [SW-1:0] sum;
    logic          flag_q;

    // Population count of the accepted strobes this cycle.
    always_comb begin
        pop = '0;
        for (int i = 0; i < N; i++) begin
            pop = pop + SW'(accept_i[i]);
        end
        sum = SW'(tally_q) + pop;
    end

    // Advance the tally; on completion clear it and flip the global flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
            flag_q  <= 1'b0;
        end else if (sum == SW'(N)) begin
            tally_q <= '0;
            flag_q  <= ~flag_q;
        end else begin
            tally_q <= sum[CW-1:0];
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/sense_barrier.sv
// Module: sense_barrier (top)
// Centralised barrier for N agents that uses sense reversal. One slot per agent
// is built with a generate loop, and all slots share a single tally and flag.
// Assumes each agent strobes once per round. Extra strobes while waiting are
// ignored.
module sense_barrier #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] arrive_i,
    output logic [N-1:0] release_o
);

    logic [N-1:0] accept;
    logic [N-1:0] waiting;
    logic [N-1:0] sense;
    logic         gflag;

    // One state slot per agent.
    for (genvar g = 0; g < N; g++) begin : g_slot
        barrier_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .arrive_i  (arrive_i[g]),
            .flag_i    (gflag),
            .accept_o  (accept[g]),
            .release_o (release_o[g]),
            .waiting_o (waiting[g]),
            .sense_o   (sense[g])
        );
    end

    barrier_tally #(.N(N)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .flag_o   (gflag)
    );

endmodule

// File: rtl/sense_barrier_chk.sv
// Module: sense_barrier_chk
// Protocol checker that is bound into sense_barrier. It observes the ports,
// the global flag and the per-agent waiting and sense vectors.
module sense_barrier_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] arrive_i,
    input logic [N-1:0] release_o,
    input logic         gflag,
    input logic [N-1:0] waiting,
    input logic [N-1:0] sense
);

    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> (&release_o)); // R4

    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |=> (release_o == '0)); // R4

    AST_RELEASE_AFTER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> (gflag != $past(gflag))); // R4

    AST_FLIP_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (gflag != $past(gflag)) |-> (&waiting)); // R2

    AST_WAITERS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (((sense & waiting) == '0) || ((sense & waiting) == waiting))); // R6

    AST_IGNORE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arrive_i & waiting)) |=>
        (((sense ^ $past(sense)) & $past(arrive_i & waiting)) == '0)); // R5

endmodule

bind sense_barrier sense_barrier_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive_i),
    .release_o (release_o),
    .gflag     (gflag),
    .waiting   (waiting),
    .sense     (sense)
);

// File: tb/tb_sense_barrier.sv
`timescale 1ns/1ps
// Bench for sense_barrier. A behavioural model (round counter, waiting set,
// pending-release bit) predicts release_o, and the design is compared with it
// on every clock.
module tb_sense_barrier;
    localparam int N = 4;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] release_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // Behavioural model state.
    logic [N-1:0] m_wait;
    int           m_cnt;
    bit           m_pend;

    always #2.5 clk = ~clk;

    sense_barrier #(.N(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (release_o)
    );

    // Model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wait = '0;
            m_cnt  = 0;
            m_pend = 1'b0;
        end else if (m_pend) begin
            m_wait = '0;
            m_pend = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (arrive[i] && !m_wait[i]) begin
                    m_wait[i] = 1'b1;
                    m_cnt++;
                end
            end
            if (m_cnt == N) begin
                m_cnt  = 0;
                m_pend = 1'b1;
            end
        end
    end

    // Compare release_o with the model away from the clock edge.
    task automatic check(input string req);
        logic [N-1:0] exp;
        exp = m_pend ? ALL : '0;
        vectors++;
        if (release_o !== exp) begin
            fails++;
            $display("FAIL %s release_o actual=%b expected=%b at %0t",
                     req, release_o, exp, $time);
        end
    endtask

    // Check the result of the previous cycle, then drive the next strobe.
    task automatic cyc(input logic [N-1:0] a, input string req);
        @(negedge clk);
        check(req);
        arrive = a;
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) cyc('0, req);
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1");
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: single arrivals with gaps; no release before the fourth
        cyc(4'b0001, "R2"); idle(2, "R2");
        cyc(4'b0100, "R2"); idle(3, "R2");
        cyc(4'b0010, "R2"); idle(1, "R2");
        cyc(4'b1000, "R2"); idle(3, "R4");

        // R3: all agents together, then pairs
        cyc(4'b1111, "R3"); idle(3, "R3");
        cyc(4'b0011, "R3"); idle(1, "R3");
        cyc(4'b1100, "R3"); idle(3, "R3");

        // R5: repeated strobes from waiting agents are ignored
        cyc(4'b0001, "R5");
        cyc(4'b0001, "R5");
        cyc(4'b0011, "R5");
        cyc(4'b0011, "R5");
        cyc(4'b0111, "R5"); idle(2, "R5");
        cyc(4'b1000, "R5");
        cyc(4'b1111, "R5");        // lands in release cycle: ignored
        idle(3, "R5");

        // R6: immediate re-entry, not released early
        cyc(4'b1111, "R6");
        idle(1, "R6");
        cyc(4'b0001, "R6");        // re-enters right after release
        idle(4, "R6");
        cyc(4'b0110, "R6"); idle(2, "R6");
        cyc(4'b1000, "R6"); idle(2, "R6");
        for (int k = 0; k < 20; k++) cyc(4'b1111, "R6");
        idle(2, "R6");

        // R7: a partial round holds for a long time
        cyc(4'b1011, "R7");
        idle(60, "R7");
        cyc(4'b0100, "R7"); idle(3, "R7");

        // Random patterns cover all requirements together
        for (int k = 0; k < 3000; k++) cyc(N'($urandom), "R3");
        idle(3, "R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule